// File: doc/BRIEF.md
# SMI Event Status and Enable Unit

This block gathers seven power-management event sources into a status register and raises a single system-management interrupt request while any flagged event is also enabled. Five sources arrive as one-cycle pulses from neighbouring logic: primary activity, the secondary event timer, two general-purpose timers (GP0 and GP1) and legacy USB. Software produces the other two. A write to a command port flags a software SMI. Setting a release control bit flags a BIOS event.

Software reaches the block through a byte-addressed register port with two byte lanes. Status bits can only be cleared by writing one to them. Clearing the BIOS flag also drops the release bit that raised it. When a separate reload-enable input is high, a primary activity pulse also requests a reload of the GP0 timer.

Top module: `smi_evt_unit`

## Requirements
- R1: After reset, every status, enable and release bit is 0. Bits 15..7 of the status word (byte address 28h) and of the enable word (2Ah) always read 0, and bits 15..1 of the release word (2Ch) always read 0.
- R2: A one-cycle pulse on a hardware event input sets its status bit on the next clock edge. The bits are: bit 0 primary activity, bit 1 secondary timer, bit 2 GP0 timeout, bit 3 GP1 timeout, bit 4 legacy USB.
- R3: A write to 28h with the low byte lane enabled clears each status bit written as 1. Bits written as 0 are left unchanged. A write to 28h with the low lane disabled changes nothing.
- R4: If an event pulse and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R5: A write to byte 2Fh (word 2Eh with the high lane enabled) sets status bit 6. A write to word 2Eh with only the low lane enabled does not set it.
- R6: Bit 0 of the release register at 2Ch is read/write through the low lane. Writing it as 1 also sets status bit 5. Writing it as 0 clears only the release bit and leaves bit 5 unchanged.
- R7: Clearing status bit 5 by a write-1 clears the release bit on the same clock edge.
- R8: Bits 6..0 of the enable register at 2Ah are read/write through the low lane and use the status bit positions. A write with the low lane disabled leaves them unchanged.
- R9: `smi_req` is a registered level. It is 1 in the cycle after any status bit and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R10: `gp0_reload` is 1 in the cycle after a primary activity pulse that arrives while `gp0_rld_en` is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address; bit 0 selects nothing, the lanes do |
| reg_be | input | 2 | Byte lane enables (bit 0 low byte) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word (combinational) |
| evt_pri_act | input | 1 | Primary activity pulse |
| evt_sec_tmo | input | 1 | Secondary event timer timeout pulse |
| evt_gp0_tmo | input | 1 | GP0 timer timeout pulse |
| evt_gp1_tmo | input | 1 | GP1 timer timeout pulse |
| evt_usb | input | 1 | Legacy USB event pulse |
| gp0_rld_en | input | 1 | Allows primary activity to reload the GP0 timer |
| gp0_reload | output | 1 | GP0 timer reload request |
| gbl_rls | output | 1 | Release control bit |
| smi_req | output | 1 | SMI request level |

## Verification
Status, enable and release bits change on the clock edge that takes the write or pulse, so they are visible one cycle after the stimulus. Read data follows the address combinationally in that same cycle. `smi_req` and `gp0_reload` each pass through one further register, so they are due one edge after the state that causes them. A cycle-level model in the bench advances at every rising edge from the inputs held since the previous falling edge. The design's outputs are compared with that model at each falling edge, where every one of these delays has settled.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int NEVT   = 7;
  localparam int DATA_W = 16;

  typedef enum int {
    EV_PRI  = 0,
    EV_SEC  = 1,
    EV_GP0  = 2,
    EV_GP1  = 3,
    EV_USB  = 4,
    EV_BIOS = 5,
    EV_SW   = 6
  } evt_idx_e;

  // Next status: a hardware set overrides a software clear
  function automatic logic [NEVT-1:0] sts_next(input logic [NEVT-1:0] cur,
                                               input logic [NEVT-1:0] clr,
                                               input logic [NEVT-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_pending(input logic [NEVT-1:0] sts,
                                       input logic [NEVT-1:0] en);
    return |(sts & en);
  endfunction
endpackage

// File: rtl/smi_reg_decode.sv
module smi_reg_decode #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NEVT     = 7,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h2A,
  parameter logic [ADDR_W-1:0] RLS_ADDR = 8'h2C,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h2F
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NEVT-1:0]   sts_q,
  input  logic [NEVT-1:0]   en_q,
  input  logic              rls_q,
  output logic [NEVT-1:0]   clr_vec,
  output logic              en_wr,
  output logic              rls_wr,
  output logic              cmd_wr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int WA = ADDR_W - 1;
  localparam logic CMD_LANE = CMD_ADDR[0];

  logic hit_sts, hit_en, hit_rls, hit_cmd;

  always_comb begin
    hit_sts = reg_addr[WA:1] == STS_ADDR[WA:1];
    hit_en  = reg_addr[WA:1] == EN_ADDR[WA:1];
    hit_rls = reg_addr[WA:1] == RLS_ADDR[WA:1];
    hit_cmd = reg_addr[WA:1] == CMD_ADDR[WA:1];
  end

  // All defined bits live in the low lane
  assign clr_vec = (reg_wr && hit_sts && reg_be[0]) ? reg_wdata[NEVT-1:0] : '0;
  assign en_wr   = reg_wr && hit_en  && reg_be[0];
  assign rls_wr  = reg_wr && hit_rls && reg_be[0];
  assign cmd_wr  = reg_wr && hit_cmd && reg_be[CMD_LANE];

  always_comb begin
    reg_rdata = '0;
    if (hit_sts)      reg_rdata[NEVT-1:0] = sts_q;
    else if (hit_en)  reg_rdata[NEVT-1:0] = en_q;
    else if (hit_rls) reg_rdata[0]        = rls_q;
  end
endmodule

// File: rtl/smi_sts_bank.sv
module smi_sts_bank #(
  parameter int NEVT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] set_vec,
  input  logic [NEVT-1:0] clr_vec,
  output logic [NEVT-1:0] sts_q
);
  import smi_pkg::*;
  logic [NEVT-1:0] nxt;
  assign nxt = sts_next(sts_q, clr_vec, set_vec);

  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[i] <= 1'b0;
      else        sts_q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/smi_evt_unit.sv
module smi_evt_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_pri_act,
  input  logic              evt_sec_tmo,
  input  logic              evt_gp0_tmo,
  input  logic              evt_gp1_tmo,
  input  logic              evt_usb,
  input  logic              gp0_rld_en,
  output logic              gp0_reload,
  output logic              gbl_rls,
  output logic              smi_req
);
  import smi_pkg::*;

  logic [NEVT-1:0] sts_q, en_q, clr_vec, set_vec;
  logic            en_wr, rls_wr, cmd_wr, rls_set;

  smi_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEVT(NEVT)) dec_i (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .sts_q(sts_q), .en_q(en_q), .rls_q(gbl_rls),
    .clr_vec(clr_vec), .en_wr(en_wr), .rls_wr(rls_wr), .cmd_wr(cmd_wr),
    .reg_rdata(reg_rdata)
  );

  assign rls_set = rls_wr && reg_wdata[0];

  always_comb begin
    set_vec          = '0;
    set_vec[EV_PRI]  = evt_pri_act;
    set_vec[EV_SEC]  = evt_sec_tmo;
    set_vec[EV_GP0]  = evt_gp0_tmo;
    set_vec[EV_GP1]  = evt_gp1_tmo;
    set_vec[EV_USB]  = evt_usb;
    set_vec[EV_BIOS] = rls_set;
    set_vec[EV_SW]   = cmd_wr;
  end

  smi_sts_bank #(.NEVT(NEVT)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .sts_q(sts_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      gbl_rls    <= 1'b0;
      smi_req    <= 1'b0;
      gp0_reload <= 1'b0;
    end else begin
      if (en_wr) en_q <= reg_wdata[NEVT-1:0];
      if (rls_wr)                gbl_rls <= reg_wdata[0];
      else if (clr_vec[EV_BIOS]) gbl_rls <= 1'b0;
      smi_req    <= any_pending(sts_q, en_q);
      gp0_reload <= evt_pri_act && gp0_rld_en;
    end
  end
endmodule

// File: rtl/smi_evt_chk.sv
module smi_evt_chk #(
  parameter int NEVT   = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEVT-1:0]   sts_q,
  input logic [NEVT-1:0]   en_q,
  input logic [NEVT-1:0]   clr_vec,
  input logic              cmd_wr,
  input logic              evt_gp0_tmo,
  input logic              evt_pri_act,
  input logic              gp0_rld_en,
  input logic              gp0_reload,
  input logic              gbl_rls,
  input logic              smi_req,
  input logic [DATA_W-1:0] reg_rdata
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NEVT] == '0); // R1
  AST_NO_SPURIOUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q) & ~$past(clr_vec) & ~sts_q) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_gp0_tmo |=> sts_q[2]); // R4
  AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> sts_q[6]); // R5
  AST_RLS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vec[5] |=> !gbl_rls); // R7
  AST_SMI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & en_q)) |=> smi_req); // R9
  AST_SMI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts_q & en_q)) |=> !smi_req); // R9
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pri_act && gp0_rld_en) |=> gp0_reload); // R10
endmodule

bind smi_evt_unit smi_evt_chk #(.NEVT(smi_pkg::NEVT), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sts_q(sts_q), .en_q(en_q), .clr_vec(clr_vec),
  .cmd_wr(cmd_wr), .evt_gp0_tmo(evt_gp0_tmo), .evt_pri_act(evt_pri_act),
  .gp0_rld_en(gp0_rld_en), .gp0_reload(gp0_reload), .gbl_rls(gbl_rls),
  .smi_req(smi_req), .reg_rdata(reg_rdata)
);

// File: tb/smi_evt_unit_tb.sv
module smi_evt_unit_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [1:0] reg_be = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic evt_pri_act = 0, evt_sec_tmo = 0, evt_gp0_tmo = 0, evt_gp1_tmo = 0, evt_usb = 0;
  logic gp0_rld_en = 0, gp0_reload, gbl_rls, smi_req;

  always #10 clk = ~clk;

  smi_evt_unit dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_sts = 0, m_en = 0, m_rls = 0, m_smi = 0, m_rld = 0;

  task automatic cmp(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int model_rd(int a);
    case (a / 2)
      8'h14: return m_sts;
      8'h15: return m_en;
      8'h16: return m_rls;
      default: return 0;
    endcase
  endfunction

  // advance one clock: update the model from the held inputs, then compare
  task automatic step();
    int clr, setm, wa;
    @(posedge clk);
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_rls = 0; m_smi = 0; m_rld = 0;
    end else begin
      wa = reg_addr / 2;
      clr = (reg_wr && wa == 8'h14 && reg_be[0]) ? (reg_wdata & 8'h7f) : 0;
      setm = 0;
      if (evt_pri_act) setm += 1;
      if (evt_sec_tmo) setm += 2;
      if (evt_gp0_tmo) setm += 4;
      if (evt_gp1_tmo) setm += 8;
      if (evt_usb)     setm += 16;
      if (reg_wr && wa == 8'h16 && reg_be[0] && reg_wdata[0]) setm += 32;
      if (reg_wr && wa == 8'h17 && reg_be[1]) setm += 64;
      m_smi = ((m_sts & m_en) != 0) ? 1 : 0;
      m_rld = (evt_pri_act && gp0_rld_en) ? 1 : 0;
      if (reg_wr && wa == 8'h16 && reg_be[0]) m_rls = reg_wdata[0];
      else if ((clr & 32) != 0) m_rls = 0;
      if (reg_wr && wa == 8'h15 && reg_be[0]) m_en = reg_wdata & 8'h7f;
      m_sts = (m_sts - (m_sts & clr)) | setm;
    end
    @(negedge clk);
    cmp("R9 smi_req", smi_req, m_smi);
    cmp("R10 gp0_reload", gp0_reload, m_rld);
    cmp("R6 gbl_rls", gbl_rls, m_rls);
    cmp("R3 read data", reg_rdata, model_rd(reg_addr));
  endtask

  task automatic wr(int a, int be, int d);
    reg_wr = 1; reg_addr = a[7:0]; reg_be = be[1:0]; reg_wdata = d[15:0];
    step();
    reg_wr = 0; reg_be = 0; reg_wdata = 0;
  endtask

  task automatic expect_rd(int a, int exp, string req);
    reg_addr = a[7:0];
    #1;
    cmp(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    expect_rd(8'h28, 0, "R1 status after reset");
    expect_rd(8'h2A, 0, "R1 enable after reset");
    expect_rd(8'h2C, 0, "R1 release after reset");
    cmp("R9 smi after reset", smi_req, 0);
    // R2: each hardware source
    evt_pri_act = 1; step(); evt_pri_act = 0;
    evt_sec_tmo = 1; step(); evt_sec_tmo = 0;
    evt_gp0_tmo = 1; step(); evt_gp0_tmo = 0;
    evt_gp1_tmo = 1; step(); evt_gp1_tmo = 0;
    evt_usb = 1; step(); evt_usb = 0;
    expect_rd(8'h28, 16'h1f, "R2 all sources set");
    // R3: zero write, disabled lane, then one clear
    wr(8'h28, 1, 0);
    expect_rd(8'h28, 16'h1f, "R3 write 0 ignored");
    wr(8'h28, 2, 16'hffff);
    expect_rd(8'h28, 16'h1f, "R3 low lane disabled");
    wr(8'h28, 3, 16'hff01);
    expect_rd(8'h28, 16'h1e, "R3 clear bit0");
    // R4: set wins over clear
    evt_gp0_tmo = 1; wr(8'h28, 1, 4); evt_gp0_tmo = 0;
    expect_rd(8'h28, 16'h1e, "R4 set beats clear");
    wr(8'h28, 1, 16'h7f);
    expect_rd(8'h28, 0, "R3 clear all");
    // R5: command port lanes
    wr(8'h2E, 1, 16'hffff);
    expect_rd(8'h28, 0, "R5 low lane no command");
    wr(8'h2F, 2, 16'h1200);
    expect_rd(8'h28, 16'h40, "R5 command sets bit6");
    // R6/R7: release bit
    wr(8'h2C, 1, 1);
    expect_rd(8'h28, 16'h60, "R6 release sets bios bit");
    cmp("R6 release high", gbl_rls, 1);
    wr(8'h2C, 1, 0);
    expect_rd(8'h28, 16'h60, "R6 release 0 keeps bios bit");
    cmp("R6 release low", gbl_rls, 0);
    wr(8'h2C, 1, 1);
    wr(8'h28, 1, 16'h20);
    cmp("R7 bios clear drops release", gbl_rls, 0);
    expect_rd(8'h28, 16'h40, "R7 bios bit cleared");
    wr(8'h28, 1, 16'h40);
    // R8/R9: enables and SMI level
    wr(8'h2A, 1, 16'hff04);
    expect_rd(8'h2A, 16'h04, "R8 enable write");
    wr(8'h2A, 2, 16'hffff);
    expect_rd(8'h2A, 16'h04, "R8 high lane only ignored");
    evt_usb = 1; step(); evt_usb = 0;
    step();
    cmp("R9 disabled source no smi", smi_req, 0);
    evt_gp0_tmo = 1; step(); evt_gp0_tmo = 0;
    cmp("R9 not yet registered", smi_req, 0);
    step();
    cmp("R9 smi asserted", smi_req, 1);
    wr(8'h28, 1, 16'h04);
    cmp("R9 smi one more cycle", smi_req, 1);
    step();
    cmp("R9 smi dropped", smi_req, 0);
    wr(8'h28, 1, 16'h7f);
    // R10: reload
    evt_pri_act = 1; step(); evt_pri_act = 0;
    cmp("R10 no reload when disabled", gp0_reload, 0);
    gp0_rld_en = 1;
    evt_pri_act = 1; step(); evt_pri_act = 0;
    cmp("R10 reload issued", gp0_reload, 1);
    step();
    cmp("R10 reload one cycle", gp0_reload, 0);
    // mixed burst against the model
    for (int i = 0; i < 40; i++) begin
      evt_pri_act = i[0]; evt_usb = i[1] & i[2]; evt_sec_tmo = (i % 5 == 0);
      reg_wr = (i % 3 == 0); reg_addr = (i % 2) ? 8'h28 : 8'h2A;
      reg_be = 2'b01; reg_wdata = 16'(i * 37);
      step();
    end
    reg_wr = 0; evt_pri_act = 0; evt_usb = 0; evt_sec_tmo = 0;
    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule